// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Shadowed Registers

This block is the serial test port of a boundary-scan bus transceiver. A 16-state controller advances on the test-mode-select line at each rising edge of the test clock. Under its control, an 8-bit instruction register and a set of data registers are loaded, shifted and updated through the serial data input and output pins. The instruction that is active selects which data register sits between the serial input and the serial output.

The data registers are a 1-bit bypass stage, a 32-bit identification register, a 48-bit boundary register with one cell per pin (a bidirectional pin shares one cell for its input and output data) and a 3-bit control register. The bypass and identification registers are bare shift chains. The boundary and control registers each have a shadow stage on every bit. The shadow stage loads on the falling clock edge in the data-update state and drives the parallel test-output buses.

The serial output and the shadow outputs change only on falling edges. Inputs are sampled only on rising edges. The pad drivers and the normal-mode transceiver path live outside this block.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The controller follows the standard 16-state test-port diagram on the TMS value at each rising TCK edge. Five consecutive TMS-high edges reach the reset state from any state.
- R2: In the instruction-capture state the instruction shift chain loads 8'b1000_0001. It shifts out LSB first on TDO, while TDI enters at the MSB.
- R3: Assertion of trst_n, or time spent in the reset state, makes the active instruction 8'hFF (bypass). It also clears every shadow bit, so bnd_out, ctl_out, test_mode and outs_hiz all read 0.
- R4: Opcode 8'hFF and every opcode not listed here select the 1-bit bypass stage. That stage captures 0, so shifting gives a 0 followed by the TDI stream delayed by one bit.
- R5: Opcode 8'h84 selects the 32-bit identification register. It captures the IDCODE parameter (default 32'h4B7A_2C35) and shifts it out LSB first. Scanning it leaves bnd_out unchanged.
- R6: Opcode 8'h82 selects the 48-bit boundary register, which captures bnd_in in the data-capture state. It leaves test_mode at 0.
- R7: A boundary or control shadow changes only on the falling TCK edge in the data-update state, or when cleared in reset. While a scan is shifting, bnd_out holds its previous value.
- R8: Opcode 8'h80 selects the boundary register with capture from bnd_in and drives test_mode to 1, so the shadow contents reach the pins.
- R9: Opcode 8'h88 drives outs_hiz to 1, keeps test_mode at 0 and places the bypass stage in the scan path.
- R10: Opcode 8'h90 selects the 3-bit control register. Its shadow drives ctl_out, and the data-capture state loads the current shadow value back into the shift chain.
- R11: tdo_en is 1 only while the controller is in the instruction-shift or data-shift state. TDO and tdo_en change only on falling TCK edges.
- R12: The first data shift happens on the first rising TCK edge after the data-shift state is entered. The first bit presented on TDO is therefore bit 0 of the captured value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in, sampled on rising TCK |
| bnd_in | input | 48 | Pin values presented to the boundary capture |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| tdo_en | output | 1 | High when tdo is driven (shift states only) |
| bnd_out | output | 48 | Boundary shadow contents for the pin drivers |
| ctl_out | output | 3 | Control register shadow contents |
| test_mode | output | 1 | Boundary shadow drives the pins |
| outs_hiz | output | 1 | Boundary outputs are to be disabled |

## Verification
The properties assume that TMS and TDI change only while TCK is low, that TCK runs freely, and that the controller state moves only on a rising edge. On that basis, whatever a register shows at a rising edge reflects the state held through the falling edge just before it. They also assume that trst_n is released away from a rising edge. The stimulus keeps within these assumptions: it changes every input half a low phase before the rising edge and releases the reset in the middle of a low phase. It then walks every opcode, an abandoned scan and a mid-run reset, and checks the whole run against a behavioural controller model on every clock.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYP, SEL_ID, SEL_BND, SEL_CTL
    } dr_sel_e;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
    localparam logic [IR_W-1:0] OP_EXTEST  = 8'h80;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h82;
    localparam logic [IR_W-1:0] OP_IDCODE  = 8'h84;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 8'h88;
    localparam logic [IR_W-1:0] OP_CTRL    = 8'h90;
    localparam logic [IR_W-1:0] IR_CAPTURE = 8'b1000_0001;

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e st
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            TS_RESET:  fsm_d.st = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   fsm_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: fsm_d.st = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: fsm_d.st = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: fsm_d.st = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: fsm_d.st = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: fsm_d.st = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: fsm_d.st = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: fsm_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: fsm_d.st = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: fsm_d.st = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: fsm_d.st = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: fsm_d.st = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: fsm_d.st = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: fsm_d.st = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: fsm_d.st = tms ? TS_SEL_DR : TS_IDLE;
            default:   fsm_d.st = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) fsm_q <= '{st: TS_RESET};
        else         fsm_q <= fsm_d;
    end

    assign st = fsm_q.st;

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      st,
    output logic            ir_lsb,
    output logic [IR_W-1:0] ir_shift,
    output dr_sel_e         sel,
    output logic            test_mode,
    output logic            outs_hiz
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
    } ir_rise_t;

    typedef struct packed {
        logic [IR_W-1:0] op;
    } ir_fall_t;

    ir_rise_t rise_d, rise_q;
    ir_fall_t fall_d, fall_q;

    always_comb begin
        rise_d = rise_q;
        fall_d = fall_q;
        case (st)
            TS_CAP_IR: rise_d.sh = IR_CAPTURE;
            TS_SHF_IR: rise_d.sh = {tdi, rise_q.sh[IR_W-1:1]};
            default:   ;
        endcase
        if (st == TS_RESET)       fall_d.op = OP_BYPASS;
        else if (st == TS_UPD_IR) fall_d.op = rise_q.sh;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) rise_q <= '0;
        else         rise_q <= rise_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) fall_q <= '{op: OP_BYPASS};
        else         fall_q <= fall_d;
    end

    always_comb begin
        unique case (fall_q.op)
            OP_SAMPLE, OP_EXTEST: sel = SEL_BND;
            OP_IDCODE:            sel = SEL_ID;
            OP_CTRL:              sel = SEL_CTL;
            default:              sel = SEL_BYP;
        endcase
    end

    assign test_mode = (fall_q.op == OP_EXTEST);
    assign outs_hiz  = (fall_q.op == OP_HIGHZ);
    assign ir_lsb    = rise_q.sh[0];
    assign ir_shift  = rise_q.sh;

endmodule

// File: rtl/scan_tap_dr.sv
`timescale 1ns/1ps
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter int              BND_W  = 48,
    parameter int              CTL_W  = 3,
    parameter logic [ID_W-1:0] IDCODE = 32'h4B7A_2C35
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_state_e       st,
    input  dr_sel_e          sel,
    input  logic [BND_W-1:0] bnd_in,
    output logic             dr_lsb,
    output logic             byp_bit,
    output logic [BND_W-1:0] bnd_out,
    output logic [CTL_W-1:0] ctl_out
);

    typedef struct packed {
        logic             byp;
        logic [ID_W-1:0]  id;
        logic [BND_W-1:0] bnd;
        logic [CTL_W-1:0] ctl;
    } dr_rise_t;

    typedef struct packed {
        logic [BND_W-1:0] bnd;
        logic [CTL_W-1:0] ctl;
    } dr_fall_t;

    dr_rise_t rise_d, rise_q;
    dr_fall_t fall_d, fall_q;

    always_comb begin
        rise_d = rise_q;
        if (st == TS_CAP_DR) begin
            unique case (sel)
                SEL_BYP: rise_d.byp = 1'b0;
                SEL_ID:  rise_d.id  = IDCODE;
                SEL_BND: rise_d.bnd = bnd_in;
                SEL_CTL: rise_d.ctl = fall_q.ctl;
                default: ;
            endcase
        end else if (st == TS_SHF_DR) begin
            unique case (sel)
                SEL_BYP: rise_d.byp = tdi;
                SEL_ID:  rise_d.id  = {tdi, rise_q.id[ID_W-1:1]};
                SEL_BND: rise_d.bnd = {tdi, rise_q.bnd[BND_W-1:1]};
                SEL_CTL: rise_d.ctl = {tdi, rise_q.ctl[CTL_W-1:1]};
                default: ;
            endcase
        end
    end

    always_comb begin
        fall_d = fall_q;
        if (st == TS_RESET) begin
            fall_d = '0;
        end else if (st == TS_UPD_DR) begin
            if (sel == SEL_BND) fall_d.bnd = rise_q.bnd;
            if (sel == SEL_CTL) fall_d.ctl = rise_q.ctl;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) rise_q <= '0;
        else         rise_q <= rise_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) fall_q <= '0;
        else         fall_q <= fall_d;
    end

    always_comb begin
        unique case (sel)
            SEL_ID:  dr_lsb = rise_q.id[0];
            SEL_BND: dr_lsb = rise_q.bnd[0];
            SEL_CTL: dr_lsb = rise_q.ctl[0];
            default: dr_lsb = rise_q.byp;
        endcase
    end

    assign byp_bit = rise_q.byp;
    assign bnd_out = fall_q.bnd;
    assign ctl_out = fall_q.ctl;

endmodule

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/1ps
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter int              BND_W  = 48,
    parameter int              CTL_W  = 3,
    parameter logic [ID_W-1:0] IDCODE = 32'h4B7A_2C35
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BND_W-1:0] bnd_in,
    output logic             tdo,
    output logic             tdo_en,
    output logic [BND_W-1:0] bnd_out,
    output logic [CTL_W-1:0] ctl_out,
    output logic             test_mode,
    output logic             outs_hiz
);

    tap_state_e      st_w;
    dr_sel_e         sel_w;
    logic            ir_lsb_w;
    logic            dr_lsb_w;
    logic            byp_w;
    logic [IR_W-1:0] ir_shift_w;

    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    out_regs_t out_d, out_q;

    scan_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .st     (st_w)
    );

    scan_tap_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .st        (st_w),
        .ir_lsb    (ir_lsb_w),
        .ir_shift  (ir_shift_w),
        .sel       (sel_w),
        .test_mode (test_mode),
        .outs_hiz  (outs_hiz)
    );

    scan_tap_dr #(
        .ID_W   (ID_W),
        .BND_W  (BND_W),
        .CTL_W  (CTL_W),
        .IDCODE (IDCODE)
    ) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .st      (st_w),
        .sel     (sel_w),
        .bnd_in  (bnd_in),
        .dr_lsb  (dr_lsb_w),
        .byp_bit (byp_w),
        .bnd_out (bnd_out),
        .ctl_out (ctl_out)
    );

    always_comb begin
        out_d     = out_q;
        out_d.en  = (st_w == TS_SHF_IR) || (st_w == TS_SHF_DR);
        out_d.tdo = (st_w == TS_SHF_IR) ? ir_lsb_w : dr_lsb_w;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign tdo    = out_q.tdo;
    assign tdo_en = out_q.en;

endmodule

// File: rtl/scan_tap_chk.sv
`timescale 1ns/1ps
module scan_tap_chk
    import scan_tap_pkg::*;
#(
    parameter int BND_W = 48,
    parameter int CTL_W = 3
) (
    input logic             tck,
    input logic             trst_n,
    input tap_state_e       st,
    input dr_sel_e          sel,
    input logic [IR_W-1:0]  ir_shift,
    input logic             byp,
    input logic             tdo_en,
    input logic [BND_W-1:0] bnd_out,
    input logic [CTL_W-1:0] ctl_out
);

    // R2
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TS_CAP_IR) |=> (ir_shift == IR_CAPTURE));

    // R3
    reset_clears_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TS_RESET) |-> (bnd_out == '0 && ctl_out == '0));

    // R4
    bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TS_CAP_DR && sel == SEL_BYP) |=> !byp);

    // R7
    shadow_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(st == TS_UPD_DR || st == TS_RESET) |-> ($stable(bnd_out) && $stable(ctl_out)));

    // R11
    tdo_drive_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (st == TS_SHF_DR || st == TS_SHF_IR));

    // R11
    tdo_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TS_SHF_DR || st == TS_SHF_IR) |-> tdo_en);

endmodule

bind scan_tap_ctrl scan_tap_chk #(.BND_W(BND_W), .CTL_W(CTL_W)) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .st       (st_w),
    .sel      (sel_w),
    .ir_shift (ir_shift_w),
    .byp      (byp_w),
    .tdo_en   (tdo_en),
    .bnd_out  (bnd_out),
    .ctl_out  (ctl_out)
);

// File: tb/tb_scan_tap_ctrl.sv
`timescale 1ns/1ps
module tb_scan_tap_ctrl;

    localparam logic [31:0] IDC = 32'h4B7A_2C35;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [47:0] bnd_in = '0;
    logic        tdo, tdo_en, test_mode, outs_hiz;
    logic [47:0] bnd_out;
    logic [2:0]  ctl_out;

    int checks = 0;
    int fails = 0;
    int mstate = 0;
    bit done = 0;

    always #10 tck = ~tck;

    scan_tap_ctrl dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bnd_in(bnd_in),
        .tdo(tdo), .tdo_en(tdo_en), .bnd_out(bnd_out), .ctl_out(ctl_out),
        .test_mode(test_mode), .outs_hiz(outs_hiz)
    );

    // behavioural controller model, states numbered along the standard diagram
    function automatic int nxt(int s, logic t);
        case (s)
            0: return t ? 0 : 1;     1: return t ? 2 : 1;
            2: return t ? 9 : 3;     3: return t ? 5 : 4;
            4: return t ? 5 : 4;     5: return t ? 8 : 6;
            6: return t ? 7 : 6;     7: return t ? 8 : 4;
            8: return t ? 2 : 1;     9: return t ? 0 : 10;
            10: return t ? 12 : 11;  11: return t ? 12 : 11;
            12: return t ? 15 : 13;  13: return t ? 14 : 13;
            14: return t ? 15 : 11;  15: return t ? 2 : 1;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // one TCK cycle: sample after the falling edge, drive, pass the rising edge
    task automatic clk(input logic t, input logic d, output logic o);
        logic shifting;
        @(negedge tck); #5;
        shifting = (mstate == 4) || (mstate == 11);
        chk("R11 tdo_en vs model", {63'd0, tdo_en}, {63'd0, shifting});
        o = tdo;
        tms = t;
        tdi = d;
        @(posedge tck); #1;
        mstate = nxt(mstate, t);
        chk("R11 tdo held over rising edge", {63'd0, tdo}, {63'd0, o});
    endtask

    task automatic ir_scan(input logic [7:0] din, output logic [7:0] dout);
        logic o;
        clk(1, 0, o); clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
        for (int i = 0; i < 8; i++) begin
            clk(i == 7, din[i], o);
            dout[i] = o;
        end
        clk(1, 0, o); clk(0, 0, o);
    endtask

    task automatic dr_scan(input int n, input logic [63:0] din,
                           output logic [63:0] dout, output logic [63:0] pre);
        logic o;
        dout = '0;
        clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
        for (int i = 0; i < n; i++) begin
            clk(i == n - 1, din[i], o);
            dout[i] = o;
        end
        clk(1, 0, o);
        pre = {16'd0, bnd_out};
        clk(0, 0, o);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0]  irv;
        logic [63:0] dv, pv;
        logic        o;
        logic [47:0] pa, pb, pc, pd;
        pa = 48'hC3A5_1F0E_9B27;
        pb = 48'h5A3C_E781_0F6D;
        pc = 48'hFEDC_BA98_7654;
        pd = 48'h0123_4567_89AB;

        // R3: reset state
        #35;
        chk("R3 bnd_out at reset", {16'd0, bnd_out}, 64'd0);
        chk("R3 ctl_out at reset", {61'd0, ctl_out}, 64'd0);
        chk("R3 test_mode at reset", {63'd0, test_mode}, 64'd0);
        chk("R11 tdo_en at reset", {63'd0, tdo_en}, 64'd0);
        @(negedge tck); #5; trst_n = 1'b1;
        mstate = 0;
        clk(0, 0, o);

        // R2: capture pattern, load IDCODE opcode
        ir_scan(8'h84, irv);
        chk("R2 IR capture value", {56'd0, irv}, 64'h81);

        // R5 / R12: identification register
        dr_scan(32, 64'd0, dv, pv);
        chk("R5 IDCODE shifted out", dv, {32'd0, IDC});
        chk("R12 first bit is captured bit 0", {63'd0, dv[0]}, {63'd0, IDC[0]});
        chk("R5 bnd_out untouched", {16'd0, bnd_out}, 64'd0);

        // R6 / R7: sample
        ir_scan(8'h82, irv);
        bnd_in = pa;
        dr_scan(48, {16'd0, pb}, dv, pv);
        chk("R6 boundary capture", dv, {16'd0, pa});
        chk("R6 test_mode off in sample", {63'd0, test_mode}, 64'd0);
        chk("R7 shadow held before update", pv, 64'd0);
        chk("R7 shadow after update", {16'd0, bnd_out}, {16'd0, pb});
        chk("R12 first sample bit", {63'd0, dv[0]}, {63'd0, pa[0]});

        // R8: external test
        ir_scan(8'h80, irv);
        chk("R8 test_mode on", {63'd0, test_mode}, 64'd1);
        bnd_in = pc;
        dr_scan(48, {16'd0, pd}, dv, pv);
        chk("R8 capture from pins", dv, {16'd0, pc});
        chk("R7 shadow held during extest scan", pv, {16'd0, pb});
        chk("R8 shadow drives bnd_out", {16'd0, bnd_out}, {16'd0, pd});

        // R10: control register
        ir_scan(8'h90, irv);
        chk("R10 test_mode off", {63'd0, test_mode}, 64'd0);
        dr_scan(3, 64'd5, dv, pv);
        chk("R10 ctl_out loaded", {61'd0, ctl_out}, 64'd5);
        dr_scan(3, 64'd2, dv, pv);
        chk("R10 capture returns shadow", dv, 64'd5);
        chk("R10 ctl_out second load", {61'd0, ctl_out}, 64'd2);
        chk("R10 bnd_out kept", {16'd0, bnd_out}, {16'd0, pd});

        // R9: high impedance with bypass path
        ir_scan(8'h88, irv);
        chk("R9 outs_hiz on", {63'd0, outs_hiz}, 64'd1);
        chk("R9 test_mode off", {63'd0, test_mode}, 64'd0);
        dr_scan(8, 64'hA5, dv, pv);
        chk("R9 bypass path", dv, 64'h4A);

        // R4: unknown opcode
        ir_scan(8'h3C, irv);
        chk("R4 outs_hiz off", {63'd0, outs_hiz}, 64'd0);
        dr_scan(8, 64'h96, dv, pv);
        chk("R4 unknown acts as bypass", dv, 64'h2C);
        chk("R4 bnd_out unchanged", {16'd0, bnd_out}, {16'd0, pd});

        // R1 / R3: abandon a scan with five TMS-high cycles
        ir_scan(8'h80, irv);
        clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
        clk(0, 1, o); clk(0, 1, o);
        for (int i = 0; i < 5; i++) clk(1, 0, o);
        chk("R1 model reached reset", mstate, 64'd0);
        clk(0, 0, o);
        chk("R3 shadows cleared via reset state", {16'd0, bnd_out}, 64'd0);
        chk("R3 ctl cleared", {61'd0, ctl_out}, 64'd0);
        chk("R3 test_mode cleared", {63'd0, test_mode}, 64'd0);
        dr_scan(8, 64'hF0, dv, pv);
        chk("R1 bypass after reset state", dv, 64'hE0);

        // R3: asynchronous reset mid-run
        ir_scan(8'h80, irv);
        dr_scan(48, {16'd0, pa}, dv, pv);
        chk("R8 pre-reset load", {16'd0, bnd_out}, {16'd0, pa});
        @(negedge tck); #5;
        tms = 1'b1;
        trst_n = 1'b0;
        #3;
        chk("R3 async clears bnd_out", {16'd0, bnd_out}, 64'd0);
        chk("R3 async clears test_mode", {63'd0, test_mode}, 64'd0);
        chk("R11 async clears tdo_en", {63'd0, tdo_en}, 64'd0);
        @(negedge tck); #5;
        trst_n = 1'b1;
        mstate = 0;
        clk(0, 0, o);
        dr_scan(4, 64'h9, dv, pv);
        chk("R4 bypass after async reset", dv, 64'h2);

        done = 1;
        finish_run();
    end

endmodule